// File: doc/BRIEF.md
# SDRAM Command Decoder with Byte-Mask Timing

This block sits on the device side of a single-data-rate SDRAM interface. On every rising clock edge it samples the clock-enable, chip-select, row-strobe, column-strobe and write-enable pins, plus the bank bits, the address bus and four byte-mask pins. One edge later it presents a one-hot command, the bank, row or column address that the command carries, the auto-precharge and all-bank flags, and the mode-register opcode.

It also drives the byte-lane controls for a 32-bit data bus. The write-lane enables act on the same cycle as the mask sample, so they line up with the decoded write. The read-output enables take effect two clocks after the mask is sampled. A width input selects 16-bit or 32-bit column decoding. In 16-bit mode only the two low byte lanes are ever enabled.

Every clock edge is a command slot. There is no handshake because the pin protocol has no way to stall the controller. The memory array, bank timing rules and burst counting sit in neighbouring blocks.

Top module: `sdr_cmd_decoder`

## Requirements
- R1: When `cs_n` is high at a sampling edge, `cmd_oh` after that edge is the no-operation code (bit 0) whatever the other pins are.
- R2: With `cs_n` low and `cke` high, `{ras_n,cas_n,we_n}` decodes to a one-hot `cmd_oh` one edge after sampling: 111 no-op (bit 0), 011 activate (bit 1), 101 read (bit 2), 100 write (bit 3), 110 burst stop (bit 4), 010 precharge (bit 5), 000 load mode (bit 8).
- R3: Pattern 001 gives auto refresh (bit 6) when `cke` is high and self-refresh entry (bit 7) when `cke` is low. Any other pattern sampled with `cke` low gives no-op (bit 0).
- R4: On activate, `row` takes `addr[11:0]` and `bank` takes `ba`.
- R5: On read or write, `col` takes `addr[7:0]` zero-extended when `wide` is 1, or `addr[8:0]` when `wide` is 0. `bank` takes `ba`. `auto_pre` equals `addr[10]` for that one cycle and is 0 after any other command.
- R6: On precharge, `all_banks` equals `addr[10]` for one cycle and is 0 after any other command. With `addr[10]` low, `bank` takes `ba`. With `addr[10]` high, `ba` is ignored and `bank` keeps its value.
- R7: On load mode, `opcode` takes `addr[10:0]`.
- R8: `row`, `col`, `bank` and `opcode` hold their values through every command that does not load them.
- R9: `wr_lane_en[i]` after an edge is the inverse of `dqm[i]` sampled at that edge. Lane i covers data bits 8i+7:8i. When `wide` is 0, lanes 2 and 3 are 0.
- R10: `rd_lane_oe` after edge k+2 equals the lane value that `wr_lane_en` showed after edge k, so read masking lags the decoded command by exactly two cycles.
- R11: While `rst` is high at an edge: `cmd_oh` is no-op, the address fields, flags and `wr_lane_en` are 0, and `rd_lane_oe` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge samples |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Address bus |
| dqm | input | 4 | Byte masks, 1 blocks the lane |
| wide | input | 1 | 1 = 32-bit column mode, 0 = 16-bit |
| cmd_oh | output | 9 | One-hot decoded command |
| bank | output | 2 | Extracted bank |
| row | output | 12 | Extracted row address |
| col | output | 9 | Extracted column address |
| auto_pre | output | 1 | Auto-precharge request for this access |
| all_banks | output | 1 | Precharge targets every bank |
| opcode | output | 11 | Mode-register opcode |
| wr_lane_en | output | 4 | Write enable per byte lane |
| rd_lane_oe | output | 4 | Read output enable per byte lane |

## Verification
Assertions check on every cycle that the block obeys chip-select inhibit and the self-refresh decode, that an activate loads the row, and that a precharge to all banks leaves the bank untouched. They also check that write lanes follow the mask with no lag and that read lanes reproduce the write-lane value two edges later. The bench covers what only scenarios can show. It sweeps every pin pattern under both clock-enable levels and both widths, with varied addresses and masks. Across that sweep it checks the full decode table, field extraction in both column widths, that untouched fields hold their values, and the reset values of the read pipeline during its first two cycles.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;
  localparam int CMD_COUNT = 9;
  localparam int CMD_IDX_W = 4;

  typedef enum logic [CMD_IDX_W-1:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_BST  = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_AREF = 4'd6,
    CMD_SREF = 4'd7,
    CMD_LMR  = 4'd8
  } cmd_e;
endpackage

// File: rtl/sdr_pin_decode.sv
module sdr_pin_decode
  import sdr_cmd_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  logic [2:0] strobes;
  logic       is_refresh;

  assign strobes    = {ras_n, cas_n, we_n};
  assign is_refresh = (strobes == 3'b001);

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      if (is_refresh) begin
        // clock-enable level splits the refresh pattern
        cmd = cke ? CMD_AREF : CMD_SREF;
      end else if (cke) begin
        case (strobes)
          3'b011:  cmd = CMD_ACT;
          3'b101:  cmd = CMD_RD;
          3'b100:  cmd = CMD_WR;
          3'b110:  cmd = CMD_BST;
          3'b010:  cmd = CMD_PRE;
          3'b000:  cmd = CMD_LMR;
          default: cmd = CMD_NOP;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdr_field_regs.sv
module sdr_field_regs
  import sdr_cmd_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 12,
  parameter int COL_W      = 9,
  parameter int COL_NARROW = 8,
  parameter int OPC_W      = 11,
  parameter int AP_BIT     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              cmd,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output logic [BANK_W-1:0] bank_q,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q,
  output logic              auto_pre_q,
  output logic              all_banks_q,
  output logic [OPC_W-1:0]  opc_q
);
  localparam logic [COL_W-1:0] NARROW_MASK = COL_W'((1 << COL_NARROW) - 1);

  logic [COL_W-1:0] col_pick;
  logic             flag_bit;

  assign flag_bit = addr[AP_BIT];
  assign col_pick = addr[COL_W-1:0] & (wide ? NARROW_MASK : {COL_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q      <= '0;
      row_q       <= '0;
      col_q       <= '0;
      auto_pre_q  <= 1'b0;
      all_banks_q <= 1'b0;
      opc_q       <= '0;
    end else begin
      auto_pre_q  <= 1'b0;
      all_banks_q <= 1'b0;
      case (cmd)
        CMD_ACT: begin
          row_q  <= addr[ROW_W-1:0];
          bank_q <= ba;
        end
        CMD_RD, CMD_WR: begin
          col_q      <= col_pick;
          bank_q     <= ba;
          auto_pre_q <= flag_bit;
        end
        CMD_PRE: begin
          all_banks_q <= flag_bit;
          if (!flag_bit) bank_q <= ba;
        end
        CMD_LMR: opc_q <= addr[OPC_W-1:0];
        default: ;
      endcase
    end
  end

  logic seen;
  always_ff @(posedge clk) seen <= ~rst;

  assert_act_row_R4: assert property (@(posedge clk) disable iff (rst)
    seen && $past(cmd == CMD_ACT) |-> row_q == $past(addr[ROW_W-1:0]));

  assert_prea_bank_hold_R6: assert property (@(posedge clk) disable iff (rst)
    seen && $past(cmd == CMD_PRE && flag_bit) |-> all_banks_q && bank_q == $past(bank_q));
endmodule

// File: rtl/sdr_mask_lanes.sv
module sdr_mask_lanes #(
  parameter int LANES        = 4,
  parameter int NARROW_LANES = 2,
  parameter int RD_LAT       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] dqm,
  input  logic             wide,
  output logic [LANES-1:0] wr_en,
  output logic [LANES-1:0] rd_en
);
  logic [LANES-1:0] lane_in;
  logic [LANES-1:0] rd_pipe [RD_LAT+1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_in[g] = ~dqm[g] & (wide | 1'(g < NARROW_LANES));
  end

  always_ff @(posedge clk) begin
    if (rst) wr_en <= '0;
    else     wr_en <= lane_in;
  end

  for (genvar s = 0; s <= RD_LAT; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) rd_pipe[s] <= '1;
        else     rd_pipe[s] <= lane_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) rd_pipe[s] <= '1;
        else     rd_pipe[s] <= rd_pipe[s-1];
      end
    end
  end

  assign rd_en = rd_pipe[RD_LAT];

  logic seen;
  always_ff @(posedge clk) seen <= ~rst;

  assert_wr_no_lag_R9: assert property (@(posedge clk) disable iff (rst)
    seen |-> wr_en == $past(lane_in));

  if (RD_LAT == 2) begin : g_rd_chk
    logic [1:0] run_cnt;
    always_ff @(posedge clk) begin
      if (rst)                run_cnt <= '0;
      else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end
    assert_rd_two_lag_R10: assert property (@(posedge clk) disable iff (rst)
      run_cnt == 2'd3 |-> rd_en == $past(wr_en, 2));
  end
endmodule

// File: rtl/sdr_cmd_decoder.sv
module sdr_cmd_decoder
  import sdr_cmd_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 12,
  parameter int COL_W      = 9,
  parameter int COL_NARROW = 8,
  parameter int OPC_W      = 11,
  parameter int AP_BIT     = 10,
  parameter int LANES      = 4,
  parameter int RD_LAT     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  dqm,
  input  logic              wide,
  output logic [CMD_COUNT-1:0] cmd_oh,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic              auto_pre,
  output logic              all_banks,
  output logic [OPC_W-1:0]  opcode,
  output logic [LANES-1:0]  wr_lane_en,
  output logic [LANES-1:0]  rd_lane_oe
);
  localparam int NARROW_LANES = LANES / 2;

  cmd_e                 cmd;
  logic [CMD_IDX_W-1:0] cmd_code;

  sdr_pin_decode u_decode (
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  assign cmd_code = cmd;

  for (genvar i = 0; i < CMD_COUNT; i++) begin : g_oh
    always_ff @(posedge clk) begin
      if (rst) cmd_oh[i] <= (i == 0);
      else     cmd_oh[i] <= (cmd_code == CMD_IDX_W'(i));
    end
  end

  sdr_field_regs #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .COL_NARROW(COL_NARROW), .OPC_W(OPC_W), .AP_BIT(AP_BIT)
  ) u_fields (
    .clk         (clk),
    .rst         (rst),
    .cmd         (cmd),
    .ba          (ba),
    .addr        (addr),
    .wide        (wide),
    .bank_q      (bank),
    .row_q       (row),
    .col_q       (col),
    .auto_pre_q  (auto_pre),
    .all_banks_q (all_banks),
    .opc_q       (opcode)
  );

  sdr_mask_lanes #(
    .LANES(LANES), .NARROW_LANES(NARROW_LANES), .RD_LAT(RD_LAT)
  ) u_lanes (
    .clk   (clk),
    .rst   (rst),
    .dqm   (dqm),
    .wide  (wide),
    .wr_en (wr_lane_en),
    .rd_en (rd_lane_oe)
  );

  logic seen;
  always_ff @(posedge clk) seen <= ~rst;

  assert_inhibit_nop_R1: assert property (@(posedge clk) disable iff (rst)
    seen && $past(cs_n) |-> cmd_oh == CMD_COUNT'(1));

  assert_self_refresh_R3: assert property (@(posedge clk) disable iff (rst)
    seen && $past(!cs_n && !ras_n && !cas_n && we_n && !cke) |-> cmd_oh[CMD_SREF] && $onehot(cmd_oh));
endmodule

// File: tb/sdr_cmd_decoder_tb.sv
module sdr_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke, cs_n, ras_n, cas_n, we_n, wide;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [3:0]  dqm;
  logic [8:0]  cmd_oh;
  logic [1:0]  bank;
  logic [11:0] row;
  logic [8:0]  col;
  logic        auto_pre, all_banks;
  logic [10:0] opcode;
  logic [3:0]  wr_lane_en, rd_lane_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state derived from the requirements
  logic [1:0]  m_bank;
  logic [11:0] m_row;
  logic [8:0]  m_col;
  logic [10:0] m_opc;
  logic [3:0]  lane_d1, lane_d2;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_cmd_decoder dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .wide(wide),
    .cmd_oh(cmd_oh), .bank(bank), .row(row), .col(col), .auto_pre(auto_pre),
    .all_banks(all_banks), .opcode(opcode), .wr_lane_en(wr_lane_en),
    .rd_lane_oe(rd_lane_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_idx(input bit k, input bit c, input bit [2:0] p);
    if (c) return 0;
    if (p == 3'b001) return k ? 6 : 7;
    if (!k) return 0;
    case (p)
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b110: return 4;
      3'b010: return 5;
      3'b000: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic step(input bit k, input bit c, input bit [2:0] p, input logic [1:0] b,
                      input logic [11:0] a, input logic [3:0] m, input bit w);
    int idx;
    logic [3:0] lane_now;
    logic       exp_ap, exp_all;
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = p; ba = b; addr = a; dqm = m; wide = w;
    @(posedge clk);
    @(negedge clk);
    idx = exp_idx(k, c, p);
    exp_ap = 1'b0; exp_all = 1'b0;
    case (idx)
      1: begin m_row = a; m_bank = b; end
      2, 3: begin m_col = w ? {1'b0, a[7:0]} : a[8:0]; m_bank = b; exp_ap = a[10]; end
      5: begin exp_all = a[10]; if (!a[10]) m_bank = b; end
      8: m_opc = a[10:0];
      default: ;
    endcase
    if (c)                     chk("R1 inhibit", 32'(cmd_oh), 32'h1);
    else if (p == 3'b001 || !k) chk("R3 refresh/cke", 32'(cmd_oh), 32'(9'b1 << idx));
    else                       chk("R2 decode", 32'(cmd_oh), 32'(9'b1 << idx));
    chk(idx == 1 ? "R4 row" : "R8 row hold", 32'(row), 32'(m_row));
    chk((idx == 2 || idx == 3) ? "R5 column" : "R8 column hold", 32'(col), 32'(m_col));
    chk("R5 auto precharge", 32'(auto_pre), 32'(exp_ap));
    chk("R6 all banks", 32'(all_banks), 32'(exp_all));
    chk(idx == 5 ? "R6 precharge bank" : "R8 bank", 32'(bank), 32'(m_bank));
    chk(idx == 8 ? "R7 opcode" : "R8 opcode hold", 32'(opcode), 32'(m_opc));
    lane_now = ~m & (w ? 4'hF : 4'h3);
    chk("R9 write lanes", 32'(wr_lane_en), 32'(lane_now));
    chk("R10 read lanes", 32'(rd_lane_oe), 32'(lane_d2));
    lane_d2 = lane_d1;
    lane_d1 = lane_now;
  endtask

  initial begin
    cke = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b101;
    ba = 2'd3; addr = 12'hFFF; dqm = 4'h0; wide = 1'b1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset command", 32'(cmd_oh), 32'h1);
    chk("R11 reset fields", 32'({bank, row, col, opcode, auto_pre, all_banks}), 32'h0);
    chk("R11 reset write lanes", 32'(wr_lane_en), 32'h0);
    chk("R11 reset read lanes", 32'(rd_lane_oe), 32'hF);
    rst = 1'b0;
    m_bank = '0; m_row = '0; m_col = '0; m_opc = '0;
    lane_d1 = 4'hF; lane_d2 = 4'hF;
    for (int rep = 0; rep < 4; rep++) begin
      for (int combo = 0; combo < 128; combo++) begin
        logic [11:0] a;
        a = 12'((combo * 173 + rep * 911) ^ 12'h6B3);
        a[10] = 1'(combo) ^ 1'(rep);
        step(combo[6], combo[5], 3'(combo >> 2), 2'(combo + rep), a,
             4'(combo * 7 + rep * 3), combo[1]);
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule